// File: doc/BRIEF.md
# Prescaled Free-Running Timer Counter

This block is a 16-bit up-counting timebase that a processor reaches over an 8-bit register bus. The count is visible as a high byte and a low byte, and a second address pair returns the very same count. The counter never stops. The only value it is ever loaded with is FFFCh, both at reset and when software writes either low-byte address. The count rate comes from a small prescaler. It can divide the system clock by 2, 4 or 8, or it can follow the rising edges of an external clock pin, which is first brought into the clock domain by a synchronizer.

When the count rolls over from FFFFh to 0000h, the block raises a one-cycle overflow event output and sets an overflow flag in its status byte. The flag drives an interrupt request line when the overflow enable bit is set. Software clears the flag with a two-step handshake: it reads the status byte while the flag is set, then it reads the main low byte. Reads of the second (alias) pair never clear the flag, so a monitor can look at the count without disturbing interrupt handling.

A read of either high byte captures the matching low byte in a holding register. This keeps a high-then-low 16-bit read coherent while the counter keeps running.

Its behaviour rests on three small state machines:
- Flag state machine. States FLG_IDLE and FLG_ARMED. The transition arm goes from FLG_IDLE to FLG_ARMED on a status read while the flag is set. The transition clear goes from FLG_ARMED to FLG_IDLE on a main low-byte read, and it clears the flag.
- Holding state machines, one per address pair. States HOLD_LIVE and HOLD_HELD. The transition capture goes to HOLD_HELD on a high-byte read. The transition release goes back to HOLD_LIVE on the next low-byte read of that pair.

Top module: `frc_timebase`

## Requirements
- R1: After reset the count is FFFCh, the overflow flag is 0, the control byte is 00h (divide by 2, interrupt disabled) and `ovf_irq` is low.
- R2: Register addresses are fixed as follows. 0 is the main high byte, 1 the main low byte, 2 the alias high byte, 3 the alias low byte, 4 the status byte (bit 7 is the flag, all other bits read 0) and 5 the control byte (bits 1:0 select the clock, bit 7 enables the overflow interrupt, all other bits read 0). Addresses 6 and 7 read 00h, and `bus_rdata` is 00h whenever no read is strobed.
- R3: A write of any value to address 1 or address 3 sets the count to FFFCh and restarts the prescaler. Writes to addresses 0, 2 and 4 change neither the count nor the flag.
- R4: The alias pair returns the same count as the main pair. A read of address 3 never clears the flag.
- R5: Clock select 00 advances the count once every 2 clocks, 01 once every 4 clocks and 10 once every 8 clocks (N). The first step comes N clocks after a reload, and the rollover repeats every 65536·N clocks.
- R6: Clock select 11 advances the count by exactly one for each rising edge on `ext_clk`. The step lands on the third clock edge after the rise, and a steady level adds nothing.
- R7: On the clock edge that takes the count from FFFFh to 0000h, the flag is set and `ovf_pulse` is high for exactly that one cycle.
- R8: The flag clears only when a main low-byte read follows a status read made while the flag was set. A main low-byte read without that status read, or a write to the counter, leaves the flag set.
- R9: `ovf_irq` is high exactly when the flag is set and control bit 7 is 1.
- R10: A high-byte read latches that pair's low byte. The next low-byte read of the same pair returns the latched value, and later low-byte reads return the live count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_rd | input | 1 | Read strobe; its side effects happen at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| ext_clk | input | 1 | External count clock, asynchronous |
| ovf_irq | output | 1 | Overflow interrupt request |
| ovf_pulse | output | 1 | One-cycle rollover event |

## Verification
Read data is combinational, so a read returns the state left by the previous clock edge. Its side effects (latching the low byte, arming the flag, clearing the flag) take effect at the edge that ends the strobe. A reload written at edge E puts the count at FFFCh + floor(k/N) when it is sampled k edges later. The rollover and its pulse land exactly 4·N edges after E. An external rise shows up three edges later.

The bench stamps every edge with a cycle counter. It drives inputs just after an edge and samples read data and outputs just before the next edge. It computes every expected count from the cycle distance to the last reload, so each check falls in the cycle where the value is due.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int unsigned FRC_ADDR_W = 3;
    localparam int unsigned FRC_PRE_W  = 3;

    typedef enum logic [1:0] {
        CSEL_DIV2 = 2'd0,
        CSEL_DIV4 = 2'd1,
        CSEL_DIV8 = 2'd2,
        CSEL_EXT  = 2'd3
    } csel_e;

    typedef enum logic [FRC_ADDR_W-1:0] {
        RA_MAIN_HI = 3'd0,
        RA_MAIN_LO = 3'd1,
        RA_ALT_HI  = 3'd2,
        RA_ALT_LO  = 3'd3,
        RA_STATUS  = 3'd4,
        RA_CONTROL = 3'd5
    } raddr_e;

    typedef enum logic {
        FLG_IDLE  = 1'b0,
        FLG_ARMED = 1'b1
    } flg_st_e;

    typedef enum logic {
        HOLD_LIVE = 1'b0,
        HOLD_HELD = 1'b1
    } hold_st_e;

endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler
    import frc_pkg::*;
#(
    parameter int unsigned DIV_W  = FRC_PRE_W,
    parameter int unsigned SYNC_N = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  csel_e sel,
    input  logic  ext_in,
    output logic  tick
);

    localparam int unsigned PIPE_W = SYNC_N + 1;

    logic [DIV_W-1:0]  div_q;
    logic [PIPE_W-1:0] ext_q;
    logic              ext_rise;

    // divider runs freely and restarts with the counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // synchronizer stages followed by one history stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else begin
            ext_q <= {ext_q[PIPE_W-2:0], ext_in};
        end
    end

    assign ext_rise = ext_q[SYNC_N-1] & ~ext_q[SYNC_N];

    always_comb begin
        unique case (sel)
            CSEL_DIV2: tick = div_q[0];
            CSEL_DIV4: tick = &div_q[1:0];
            CSEL_DIV8: tick = &div_q[DIV_W-1:0];
            CSEL_EXT:  tick = ext_rise;
        endcase
    end

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int unsigned         CNT_W  = 16,
    parameter logic [CNT_W-1:0]    RELOAD = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_ev,
    output logic             wrap_pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;

    assign wrap_ev = tick & (&cnt_q) & ~reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= RELOAD;
            pulse_q <= 1'b0;
        end else if (reload) begin
            cnt_q   <= RELOAD;
            pulse_q <= 1'b0;
        end else begin
            if (tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            pulse_q <= wrap_ev;
        end
    end

    assign cnt        = cnt_q;
    assign wrap_pulse = pulse_q;

endmodule

// File: rtl/frc_flag_ctl.sv
module frc_flag_ctl
    import frc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic stat_rd,
    input  logic lo_rd,
    output logic flag,
    output logic armed
);

    flg_st_e state_q, state_d;
    logic    flag_q, flag_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            flag_q  <= flag_d;
        end
    end

    // transitions: arm, clear; a new rollover always wins over clear
    always_comb begin
        state_d = state_q;
        flag_d  = flag_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (stat_rd && flag_q) begin
                    state_d = FLG_ARMED;
                end
            end
            FLG_ARMED: begin
                if (lo_rd) begin
                    state_d = FLG_IDLE;
                    flag_d  = 1'b0;
                end
            end
        endcase
        if (set_ev) begin
            flag_d = 1'b1;
        end
    end

    // outputs
    always_comb begin
        flag  = flag_q;
        armed = (state_q == FLG_ARMED);
    end

endmodule

// File: rtl/frc_byte_hold.sv
module frc_byte_hold
    import frc_pkg::*;
#(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hi_rd,
    input  logic          lo_rd,
    input  logic [BW-1:0] live_lo,
    output logic [BW-1:0] lo_view
);

    hold_st_e      state_q, state_d;
    logic [BW-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_LIVE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hi_rd) begin
                hold_q <= live_lo;
            end
        end
    end

    // transitions: capture on high read, release on low read
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_LIVE: if (hi_rd) state_d = HOLD_HELD;
            HOLD_HELD: if (hi_rd) state_d = HOLD_HELD;
                       else if (lo_rd) state_d = HOLD_LIVE;
        endcase
    end

    always_comb begin
        lo_view = (state_q == HOLD_HELD) ? hold_q : live_lo;
    end

endmodule

// File: rtl/frc_timebase.sv
module frc_timebase
    import frc_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned RELOAD_VAL = 32'h0000_FFFC,
    parameter int unsigned SYNC_N     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [FRC_ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0]     bus_wdata,
    output logic [BYTE_W-1:0]     bus_rdata,
    input  logic                  ext_clk,
    output logic                  ovf_irq,
    output logic                  ovf_pulse
);

    localparam int unsigned    CNT_W    = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] RELOAD_C = CNT_W'(RELOAD_VAL);
    localparam int unsigned    N_PAIRS  = 2;

    logic              rd_stb, wr_stb;
    logic              reload, tick, wrap_ev;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] cnt_hi, cnt_lo;
    logic              flag_q, flag_armed;
    logic              stat_rd;
    csel_e             csel_q;
    logic              ovf_en_q;
    logic [N_PAIRS-1:0] hi_rd, lo_rd;
    logic [BYTE_W-1:0] lo_view [N_PAIRS];
    logic              unused_wbits;

    assign rd_stb  = bus_sel & bus_rd;
    assign wr_stb  = bus_sel & bus_wr;
    assign reload  = wr_stb & ((bus_addr == RA_MAIN_LO) | (bus_addr == RA_ALT_LO));
    assign stat_rd = rd_stb & (bus_addr == RA_STATUS);
    assign cnt_hi  = cnt_q[CNT_W-1:BYTE_W];
    assign cnt_lo  = cnt_q[BYTE_W-1:0];
    assign unused_wbits = ^bus_wdata[BYTE_W-2:2];

    // control byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csel_q   <= CSEL_DIV2;
            ovf_en_q <= 1'b0;
        end else if (wr_stb && (bus_addr == RA_CONTROL)) begin
            csel_q   <= csel_e'(bus_wdata[1:0]);
            ovf_en_q <= bus_wdata[BYTE_W-1];
        end
    end

    frc_prescaler #(
        .DIV_W (FRC_PRE_W),
        .SYNC_N(SYNC_N)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(reload),
        .sel    (csel_q),
        .ext_in (ext_clk),
        .tick   (tick)
    );

    frc_counter #(
        .CNT_W (CNT_W),
        .RELOAD(RELOAD_C)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .tick      (tick),
        .cnt       (cnt_q),
        .wrap_ev   (wrap_ev),
        .wrap_pulse(ovf_pulse)
    );

    frc_flag_ctl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (wrap_ev),
        .stat_rd(stat_rd),
        .lo_rd  (lo_rd[0]),
        .flag   (flag_q),
        .armed  (flag_armed)
    );

    // pair 0 is the main pair, pair 1 the alias pair
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        localparam raddr_e HI_A = (p == 0) ? RA_MAIN_HI : RA_ALT_HI;
        localparam raddr_e LO_A = (p == 0) ? RA_MAIN_LO : RA_ALT_LO;

        assign hi_rd[p] = rd_stb & (bus_addr == HI_A);
        assign lo_rd[p] = rd_stb & (bus_addr == LO_A);

        frc_byte_hold #(.BW(BYTE_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .hi_rd  (hi_rd[p]),
            .lo_rd  (lo_rd[p]),
            .live_lo(cnt_lo),
            .lo_view(lo_view[p])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (raddr_e'(bus_addr))
                RA_MAIN_HI: bus_rdata = cnt_hi;
                RA_MAIN_LO: bus_rdata = lo_view[0];
                RA_ALT_HI:  bus_rdata = cnt_hi;
                RA_ALT_LO:  bus_rdata = lo_view[1];
                RA_STATUS:  bus_rdata = {flag_q, {(BYTE_W-1){1'b0}}};
                RA_CONTROL: bus_rdata = {ovf_en_q, {(BYTE_W-3){1'b0}}, csel_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign ovf_irq = flag_q & ovf_en_q;

endmodule

// File: rtl/frc_timebase_chk.sv
module frc_timebase_chk #(
    parameter int unsigned         CNT_W  = 16,
    parameter int unsigned         BYTE_W = 8,
    parameter logic [CNT_W-1:0]    RELOAD = 16'hFFFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              ovf_irq,
    input logic              ovf_pulse,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic              armed
);

    logic rd_s, wr_lo, main_lo_rd, alt_lo_rd;

    assign rd_s       = bus_sel & bus_rd;
    assign wr_lo      = bus_sel & bus_wr & ((bus_addr == 3'd1) | (bus_addr == 3'd3));
    assign main_lo_rd = rd_s & (bus_addr == 3'd1);
    assign alt_lo_rd  = rd_s & (bus_addr == 3'd3);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt == RELOAD) && !flag);

    a_r2_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_s |-> (bus_rdata == '0));

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt == RELOAD));

    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_lo) && (cnt != $past(cnt))) |-> (cnt == CNT_W'($past(cnt) + 1)));

    a_r4_alt_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_lo_rd && flag) |=> flag);

    a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt) == '1) && (cnt == '0)) |-> (flag && ovf_pulse));

    a_r7_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> flag);

    a_r8_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(armed) && $past(main_lo_rd)));

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> flag);

endmodule

bind frc_timebase frc_timebase_chk #(
    .CNT_W (CNT_W),
    .BYTE_W(BYTE_W),
    .RELOAD(RELOAD_C)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .ovf_irq  (ovf_irq),
    .ovf_pulse(ovf_pulse),
    .cnt      (cnt_q),
    .flag     (flag_q),
    .armed    (flag_armed)
);

// File: tb/tb_frc_timebase.sv
`timescale 1ns/1ps
module tb_frc_timebase;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       ovf_irq, ovf_pulse;

    int cyc = 0;
    int n_chk = 0, n_err = 0;
    int c_rel = 0;
    int pulse_cnt = 0, last_pulse = 0, prev_pulse = 0;
    bit done = 0;

    frc_timebase dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ext_clk(ext_clk), .ovf_irq(ovf_irq),
        .ovf_pulse(ovf_pulse)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (ovf_pulse) begin
            prev_pulse = last_pulse;
            last_pulse = cyc;
            pulse_cnt  = pulse_cnt + 1;
        end
    end

    function automatic logic [15:0] exp_cnt(int k, int n);
        return 16'((32'hFFFC + k / n) & 32'hFFFF);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d, output int at);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_wr = 0; bus_addr = a;
        #2;
        d  = bus_rdata;
        at = cyc;
        @(posedge clk);
        #1;
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 0; bus_wr = 0;
        if (a == 3'd1 || a == 3'd3) c_rel = cyc;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        int at, at2, n, p0;
        logic [15:0] e;
        void'($urandom(32'd20240611));

        // ---- R1 / R2 reset state
        repeat (5) @(negedge clk);
        rst_n = 1;
        c_rel = cyc;
        rd(3'd0, d, at);
        e = exp_cnt(at - c_rel, 2);
        check("R1 reset high byte", d, e[15:8]);
        rd(3'd1, d, at2);
        check("R1 reset low byte", d, e[7:0]);
        rd(3'd4, d, at); check("R1 status after reset", d, 8'h00);
        rd(3'd5, d, at); check("R1 control after reset", d, 8'h00);
        check("R1 irq after reset", ovf_irq, 1'b0);
        rd(3'd6, d, at); check("R2 unmapped address", d, 8'h00);
        @(negedge clk); #1;
        check("R2 rdata without read", bus_rdata, 8'h00);

        // ---- R5 / R7 first rollover at each internal rate, R8 clear
        for (int s = 0; s < 3; s++) begin
            n = 2 << s;
            wr(3'd5, 8'(s));
            wr(3'd1, 8'h5A);
            p0 = pulse_cnt;
            idle(4 * n + 2);
            check("R7 one pulse per rollover", pulse_cnt - p0, 1);
            check("R5 R7 rollover edge after reload", last_pulse - c_rel, 4 * n);
            rd(3'd4, d, at); check("R7 flag set by rollover", d, 8'h80);
            rd(3'd1, d, at);
            rd(3'd4, d, at); check("R8 flag cleared by sequence", d, 8'h00);
        end

        // ---- random reads at internal rates, mixed pairs, ignored writes
        for (int it = 0; it < 24; it++) begin
            int s, pr;
            s  = $urandom_range(0, 2);
            pr = $urandom_range(0, 1);
            n  = 2 << s;
            wr(3'd5, 8'(s));
            wr(pr ? 3'd3 : 3'd1, 8'($urandom));
            if ($urandom_range(0, 1) == 1) begin
                int wa;
                wa = $urandom_range(0, 2) * 2;   // addresses 0, 2, 4 ignored (R3)
                wr(3'(wa), 8'($urandom));
            end
            idle($urandom_range(0, 150));
            rd(pr ? 3'd2 : 3'd0, d, at);
            rd(pr ? 3'd3 : 3'd1, d2, at2);
            e = exp_cnt(at - c_rel, n);
            check(pr ? "R4 R5 R3 alias high" : "R5 R3 main high", d, e[15:8]);
            check(pr ? "R4 R10 alias low" : "R10 main low", d2, e[7:0]);
        end

        // ---- R10 holding behaviour
        wr(3'd5, 8'h02);
        wr(3'd1, 8'h00);
        idle(10);
        rd(3'd0, d, at);
        idle(40);
        rd(3'd1, d, at2);
        e = exp_cnt(at - c_rel, 8);
        check("R10 latched low byte", d, e[7:0]);
        rd(3'd1, d, at2);
        e = exp_cnt(at2 - c_rel, 8);
        check("R10 live low byte after release", d, e[7:0]);

        // ---- R4 / R8 / R9 flag protection and interrupt
        wr(3'd5, 8'h80);
        wr(3'd3, 8'h00);
        idle(12);
        @(negedge clk); #1;
        check("R9 irq with flag and enable", ovf_irq, 1'b1);
        rd(3'd2, d, at);
        rd(3'd3, d, at);
        @(negedge clk); #1;
        check("R4 alias low read keeps flag", ovf_irq, 1'b1);
        rd(3'd1, d, at);
        @(negedge clk); #1;
        check("R8 low read without arm keeps flag", ovf_irq, 1'b1);
        wr(3'd1, 8'hFF);
        @(negedge clk); #1;
        check("R8 counter write keeps flag", ovf_irq, 1'b1);
        rd(3'd4, d, at);
        check("R8 status shows flag", d, 8'h80);
        rd(3'd3, d, at);
        @(negedge clk); #1;
        check("R4 alias read while armed keeps flag", ovf_irq, 1'b1);
        rd(3'd1, d, at);
        @(negedge clk); #1;
        check("R8 armed main low read clears", ovf_irq, 1'b0);
        wr(3'd5, 8'h02);
        wr(3'd1, 8'h00);
        idle(40);
        @(negedge clk); #1;
        check("R9 irq low with enable off", ovf_irq, 1'b0);
        rd(3'd4, d, at);
        check("R9 flag set while irq masked", d, 8'h80);
        rd(3'd1, d, at);

        // ---- R6 external clock
        wr(3'd5, 8'h03);
        wr(3'd1, 8'h00);
        p0 = pulse_cnt;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ext_clk = 1;
            repeat (3) @(negedge clk);
            ext_clk = 0;
            repeat (3) @(negedge clk);
        end
        idle(4);
        rd(3'd0, d, at); rd(3'd1, d2, at);
        check("R6 five external edges", {d, d2}, 16'h0001);
        check("R6 R7 external rollover pulse", pulse_cnt - p0, 1);
        idle(50);
        rd(3'd2, d, at); rd(3'd3, d2, at);
        check("R6 steady level holds count", {d, d2}, 16'h0001);
        @(negedge clk); ext_clk = 1;
        @(negedge clk); @(negedge clk); #1;
        rd(3'd0, d, at); rd(3'd1, d2, at);
        check("R6 step on third edge", {d, d2}, 16'h0002);
        ext_clk = 0;

        // ---- R5 full rollover period at divide by 2
        wr(3'd5, 8'h00);
        wr(3'd1, 8'h00);
        p0 = pulse_cnt;
        wait (pulse_cnt >= p0 + 2);
        check("R5 full period divide by 2", last_pulse - prev_pulse, 131072);

        done = 1;
        summary();
        $finish;
    end

endmodule